// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block turns a single high-level request into the exact series of bus cycles that a raw NAND flash device expects. The requester presents an operation code, a block index and a page index, and pulses `start`. The sequencer then drives command-latch cycles, address-latch cycles and 16-bit data cycles onto the flash bus. Each bus cycle takes one clock, and a write or read strobe marks it. After a program, erase, read-confirm or reset, the block polls the device status word until the device reports ready or a retry budget runs out. It then finishes with a one-cycle `done` pulse that carries a 2-bit result.

Page payload moves through two valid/ready streams: host-to-flash words for programming and flash-to-host words for page reads and identification. A data cycle happens on the bus only in the clock where the stream handshake completes, so either side can stall the transfer without losing a word. The block does not cover pin-level timing, error correction or bad-block handling.

Top module: `nand_op_seq`

## Requirements
- R1: The flash byte address is (block index shifted left by `BLK_SHIFT`) plus (page index shifted left by `PG_SHIFT`). The defaults are 17 and 11. A page read or page program sends five address cycles: address bits [7:0], [10:8], [18:11], [26:19] and then bit [27]. Each cycle appears zero-extended on `bus_dout[7:0]`.
- R2: Operation code 2 (page read) emits command 0x00, the five address cycles, command 0x30 and a ready poll. It then emits command 0x00 again, followed by `MAIN_WORDS`+`SPARE_WORDS` read cycles whose words appear in order on the read stream.
- R3: Operation code 3 (page program) emits command 0x80 and the five address cycles. It then takes `MAIN_WORDS`+`SPARE_WORDS` words from the write stream in order and drives each one as a write cycle, then emits command 0x10 and a ready poll.
- R4: Operation code 4 (block erase) emits command 0x60, then three address cycles that carry byte address bits [18:11], [26:19] and [34:27], then command 0xD0 and a ready poll.
- R5: Each poll attempt is a command cycle of 0x70 followed immediately by one read cycle. For page operations, the device is ready when bit 6 of the status word is set. Otherwise the block retries at once.
- R6: A bounded poll stops after `MAX_RETRY` not-ready attempts and ends with result code 2 (timeout). A page read that times out does not re-issue its read command.
- R7: After a program or erase reaches ready, status bit 0 equal to 1 gives result 1 (fail). Otherwise the result is 0 (pass).
- R8: Operation code 0 (reset) emits command 0xFF, keeps the bus idle for `RESET_WAIT` clocks, then polls. Reset is complete only when status bits 5 and 6 are both set.
- R9: A reset started with `ext_verify`=1 uses the bounded poll of R6. With `ext_verify`=0, it polls without limit until complete.
- R10: Operation code 1 (read ID) emits command 0x90 and one address cycle of 0x00. It then passes five read-cycle words to the read stream and ends with result 0.
- R11: `start` is accepted only when the block is idle and `op` is 0 to 4. `busy` stays high from acceptance through the single-cycle `done` pulse. While busy, and for an invalid code, `start` has no effect, and no bus strobe occurs while the block is idle.
- R12: A data cycle on the bus happens only together with a stream handshake: `bus_re` with `rd_valid` requires `rd_ready`, and a data write requires `wr_valid` and `wr_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| op | input | 3 | Operation code (0 reset, 1 read ID, 2 page read, 3 page program, 4 block erase) |
| blk_idx | input | BLK_W | Block index |
| pg_idx | input | PG_W | Page index within the block |
| ext_verify | input | 1 | Bound the reset poll by the retry budget |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 pass, 1 fail, 2 timeout; valid with `done` |
| bus_cle | output | 1 | Command-latch cycle |
| bus_ale | output | 1 | Address-latch cycle |
| bus_we | output | 1 | Write strobe (command, address or data) |
| bus_re | output | 1 | Read strobe |
| bus_dout | output | 16 | Value driven during a write cycle |
| bus_din | input | 16 | Value returned by the device during a read cycle |
| wr_valid | input | 1 | Host offers a program word |
| wr_ready | output | 1 | Sequencer accepts a program word |
| wr_data | input | 16 | Program word |
| rd_valid | output | 1 | Sequencer offers a read word |
| rd_ready | input | 1 | Host accepts a read word |
| rd_data | output | 16 | Read word |

## Verification
A corrupted state or counter in this block becomes visible on the bus within one clock. A wrong address shift or field split shows in the very next address cycle. An off-by-one in the word counter adds or drops a data cycle before the confirm command. A slip in the retry counter moves the timeout by one poll pair. A wrong status mask changes both the number of 0x70 cycles and the result code delivered with `done`. The comparison therefore runs per bus cycle, so the first wrong strobe or value is reported in the clock where it happens.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_RESET       = 3'd0,
        OP_READ_ID     = 3'd1,
        OP_PAGE_READ   = 3'd2,
        OP_PAGE_PROG   = 3'd3,
        OP_BLOCK_ERASE = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        RES_PASS    = 2'd0,
        RES_FAIL    = 2'd1,
        RES_TIMEOUT = 2'd2
    } res_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAIT,
        S_PCMD, S_PRD, S_CMD3, S_RDATA, S_FIN
    } st_e;

    localparam int COL_BITS = 11;
    localparam int ID_WORDS = 5;

    localparam logic [7:0] K_READ     = 8'h00;
    localparam logic [7:0] K_READ_GO  = 8'h30;
    localparam logic [7:0] K_PROG     = 8'h80;
    localparam logic [7:0] K_PROG_GO  = 8'h10;
    localparam logic [7:0] K_ERASE    = 8'h60;
    localparam logic [7:0] K_ERASE_GO = 8'hD0;
    localparam logic [7:0] K_STATUS   = 8'h70;
    localparam logic [7:0] K_IDENT    = 8'h90;
    localparam logic [7:0] K_RESET    = 8'hFF;

    function automatic logic [7:0] opening_cmd(op_e o);
        case (o)
            OP_RESET:       return K_RESET;
            OP_READ_ID:     return K_IDENT;
            OP_PAGE_PROG:   return K_PROG;
            OP_BLOCK_ERASE: return K_ERASE;
            default:        return K_READ;
        endcase
    endfunction

    function automatic logic [7:0] closing_cmd(op_e o);
        case (o)
            OP_PAGE_PROG:   return K_PROG_GO;
            OP_BLOCK_ERASE: return K_ERASE_GO;
            default:        return K_READ_GO;
        endcase
    endfunction

    // number of address cycles per operation
    function automatic logic [2:0] addr_cycles(op_e o);
        case (o)
            OP_PAGE_READ, OP_PAGE_PROG: return 3'd5;
            OP_BLOCK_ERASE:             return 3'd3;
            OP_READ_ID:                 return 3'd1;
            default:                    return 3'd0;
        endcase
    endfunction

    // bit width carried by address cycle idx
    function automatic logic [3:0] field_width(op_e o, logic [2:0] idx);
        if (o == OP_PAGE_READ || o == OP_PAGE_PROG) begin
            case (idx)
                3'd1:    return 4'd3;
                3'd4:    return 4'd1;
                default: return 4'd8;
            endcase
        end
        return 4'd8;
    endfunction

endpackage

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
    import nand_seq_pkg::*;
#(
    parameter int BLK_W     = 11,
    parameter int PG_W      = 6,
    parameter int BLK_SHIFT = 17,
    parameter int PG_SHIFT  = 11,
    parameter int ADDR_W    = 29
) (
    input  logic [BLK_W-1:0]  blk,
    input  logic [PG_W-1:0]   pg,
    input  op_e               kind,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] byte_addr;

    always_comb begin
        byte_addr = (ADDR_W'(blk) << BLK_SHIFT) + (ADDR_W'(pg) << PG_SHIFT);
        case (kind)
            OP_PAGE_READ, OP_PAGE_PROG: addr = byte_addr;
            OP_BLOCK_ERASE:             addr = byte_addr >> COL_BITS;
            default:                    addr = '0;
        endcase
    end
endmodule

// File: rtl/nand_status_eval.sv
module nand_status_eval
    import nand_seq_pkg::*;
(
    input  op_e         kind,
    input  logic [15:0] status,
    output logic        ready,
    output logic        failed
);
    always_comb begin
        if (kind == OP_RESET) ready = status[6] & status[5];
        else                  ready = status[6];
        failed = (kind == OP_PAGE_PROG || kind == OP_BLOCK_ERASE) && status[0];
    end
endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int MAIN_WORDS  = 1024,
    parameter int SPARE_WORDS = 32,
    parameter int BLK_W       = 11,
    parameter int PG_W        = 6,
    parameter int BLK_SHIFT   = 17,
    parameter int PG_SHIFT    = 11,
    parameter int MAX_RETRY   = 16,
    parameter int RESET_WAIT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [BLK_W-1:0]  blk_idx,
    input  logic [PG_W-1:0]   pg_idx,
    input  logic              ext_verify,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic              bus_cle,
    output logic              bus_ale,
    output logic              bus_we,
    output logic              bus_re,
    output logic [15:0]       bus_dout,
    input  logic [15:0]       bus_din,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [15:0]       wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [15:0]       rd_data
);
    localparam int PAGE_WORDS = MAIN_WORDS + SPARE_WORDS;
    localparam int BLK_TOP    = BLK_SHIFT + BLK_W;
    localparam int PG_TOP     = PG_SHIFT + PG_W;
    localparam int ADDR_W     = ((BLK_TOP > PG_TOP) ? BLK_TOP : PG_TOP) + 1;
    localparam int CNT_W      = $clog2(PAGE_WORDS + RESET_WAIT + 8);
    localparam int RETRY_W    = $clog2(MAX_RETRY + 1);

    typedef struct packed {
        st_e               st;
        op_e               kind;
        logic              ext;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [RETRY_W-1:0] retry;
        res_e              res;
    } seq_t;

    seq_t q, d;

    logic [ADDR_W-1:0] addr_init;
    logic              st_ready, st_failed;
    logic              op_ok;
    logic [3:0]        fw;
    logic [CNT_W-1:0]  last_word;
    logic              bounded;

    nand_addr_gen #(
        .BLK_W(BLK_W), .PG_W(PG_W), .BLK_SHIFT(BLK_SHIFT),
        .PG_SHIFT(PG_SHIFT), .ADDR_W(ADDR_W)
    ) addr_i (
        .blk(blk_idx), .pg(pg_idx), .kind(op_e'(op)), .addr(addr_init)
    );

    nand_status_eval stat_i (
        .kind(q.kind), .status(bus_din), .ready(st_ready), .failed(st_failed)
    );

    assign op_ok   = (op <= 3'd4);
    assign bounded = !(q.kind == OP_RESET && !q.ext);

    always_comb begin
        d         = q;
        bus_cle   = 1'b0;
        bus_ale   = 1'b0;
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_dout  = 16'h0000;
        wr_ready  = 1'b0;
        rd_valid  = 1'b0;
        done      = 1'b0;
        fw        = field_width(q.kind, q.cnt[2:0]);
        last_word = (q.kind == OP_READ_ID) ? CNT_W'(ID_WORDS - 1) : CNT_W'(PAGE_WORDS - 1);
        case (q.st)
            S_IDLE: begin
                if (start && op_ok) begin
                    d.kind = op_e'(op);
                    d.ext  = ext_verify;
                    d.addr = addr_init;
                    d.cnt  = '0;
                    d.res  = RES_PASS;
                    d.st   = S_CMD1;
                end
            end
            S_CMD1: begin
                bus_cle  = 1'b1;
                bus_we   = 1'b1;
                bus_dout = {8'h00, opening_cmd(q.kind)};
                d.cnt    = '0;
                if (q.kind == OP_RESET) begin
                    d.cnt = CNT_W'(RESET_WAIT - 1);
                    d.st  = S_WAIT;
                end else begin
                    d.st = S_ADDR;
                end
            end
            S_ADDR: begin
                bus_ale  = 1'b1;
                bus_we   = 1'b1;
                bus_dout = {8'h00, q.addr[7:0] & 8'((9'd1 << fw) - 9'd1)};
                d.addr   = q.addr >> fw;
                d.cnt    = q.cnt + CNT_W'(1);
                if (q.cnt[2:0] == addr_cycles(q.kind) - 3'd1) begin
                    d.cnt = '0;
                    case (q.kind)
                        OP_PAGE_PROG: d.st = S_WDATA;
                        OP_READ_ID:   d.st = S_RDATA;
                        default:      d.st = S_CMD2;
                    endcase
                end
            end
            S_WDATA: begin
                wr_ready = 1'b1;
                if (wr_valid) begin
                    bus_we   = 1'b1;
                    bus_dout = wr_data;
                    d.cnt    = q.cnt + CNT_W'(1);
                    if (q.cnt == last_word) begin
                        d.cnt = '0;
                        d.st  = S_CMD2;
                    end
                end
            end
            S_CMD2: begin
                bus_cle  = 1'b1;
                bus_we   = 1'b1;
                bus_dout = {8'h00, closing_cmd(q.kind)};
                d.retry  = RETRY_W'(MAX_RETRY);
                d.st     = S_PCMD;
            end
            S_WAIT: begin
                if (q.cnt == '0) begin
                    d.retry = RETRY_W'(MAX_RETRY);
                    d.st    = S_PCMD;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            S_PCMD: begin
                bus_cle  = 1'b1;
                bus_we   = 1'b1;
                bus_dout = {8'h00, K_STATUS};
                d.st     = S_PRD;
            end
            S_PRD: begin
                bus_re = 1'b1;
                if (st_ready) begin
                    if (q.kind == OP_PAGE_READ) begin
                        d.st = S_CMD3;
                    end else begin
                        d.res = st_failed ? RES_FAIL : RES_PASS;
                        d.st  = S_FIN;
                    end
                end else if (bounded && q.retry == RETRY_W'(1)) begin
                    d.res = RES_TIMEOUT;
                    d.st  = S_FIN;
                end else begin
                    if (bounded) d.retry = q.retry - RETRY_W'(1);
                    d.st = S_PCMD;
                end
            end
            S_CMD3: begin
                bus_cle  = 1'b1;
                bus_we   = 1'b1;
                bus_dout = {8'h00, K_READ};
                d.cnt    = '0;
                d.st     = S_RDATA;
            end
            S_RDATA: begin
                rd_valid = 1'b1;
                if (rd_ready) begin
                    bus_re = 1'b1;
                    d.cnt  = q.cnt + CNT_W'(1);
                    if (q.cnt == last_word) begin
                        d.res = RES_PASS;
                        d.st  = S_FIN;
                    end
                end
            end
            S_FIN: begin
                done = 1'b1;
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= S_IDLE;
            q.kind  <= OP_RESET;
            q.ext   <= 1'b0;
            q.addr  <= '0;
            q.cnt   <= '0;
            q.retry <= '0;
            q.res   <= RES_PASS;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != S_IDLE);
    assign result  = q.res;
    assign rd_data = bus_din;

endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [2:0]  op,
    input logic        busy,
    input logic        done,
    input logic        bus_cle,
    input logic        bus_ale,
    input logic        bus_we,
    input logic        bus_re,
    input logic [15:0] bus_dout,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic        wr_valid,
    input logic        wr_ready
);
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r11_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op <= 3'd4) |=> busy);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_we || bus_re));
    a_r12_read_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && rd_valid) |-> rd_ready);
    a_r12_write_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_cle && !bus_ale) |-> (wr_valid && wr_ready));
    a_r5_poll_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_cle && bus_dout[7:0] == 8'h70) |=> (bus_re && !rd_valid));
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re) && !(bus_cle && bus_ale));
endmodule

bind nand_op_seq nand_op_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .busy(busy), .done(done),
    .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_we(bus_we), .bus_re(bus_re),
    .bus_dout(bus_dout), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready)
);

// File: tb/nand_op_seq_tb_top.sv
module nand_op_seq_tb_top;
    localparam int MAINW  = 1024;
    localparam int SPAREW = 32;
    localparam int WORDS  = MAINW + SPAREW;
    localparam int RETRY  = 16;
    localparam int RWAIT  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op = 3'd0;
    logic [10:0] blk_idx = '0;
    logic [5:0] pg_idx = '0;
    logic ext_verify = 1'b0;
    logic busy, done;
    logic [1:0] result;
    logic bus_cle, bus_ale, bus_we, bus_re;
    logic [15:0] bus_dout, bus_din;
    logic wr_valid = 1'b0;
    logic wr_ready;
    logic [15:0] wr_data = '0;
    logic rd_valid;
    logic rd_ready = 1'b0;
    logic [15:0] rd_data;

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;

    function automatic logic [15:0] dev_word(int i);
        return 16'h5A00 ^ 16'(i * 311);
    endfunction
    function automatic logic [15:0] host_word(int i);
        return 16'hC300 + 16'(i * 3);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // device model
    int busy_polls = 0, poll_cnt = 0, didx = 0;
    logic [15:0] st_busy = 16'h0000, st_ready = 16'h0040;
    logic stat_mode = 1'b0;
    logic dev_clr = 1'b0;
    assign bus_din = stat_mode ? ((poll_cnt < busy_polls) ? st_busy : st_ready) : dev_word(didx);

    always @(posedge clk) begin
        if (dev_clr) begin
            poll_cnt <= 0; didx <= 0; stat_mode <= 1'b0;
        end else if (bus_we && bus_cle) begin
            stat_mode <= (bus_dout[7:0] == 8'h70);
            didx <= 0;
        end else if (bus_re) begin
            if (stat_mode) poll_cnt <= poll_cnt + 1;
            else didx <= didx + 1;
        end
    end

    // reference model: expected bus cycle stream
    logic [17:0] exp_q[$];
    string tag_q[$];
    bit active = 0;
    bit gap_pending = 0;
    int t_ff = 0;
    int rd_k = 0, wr_k = 0;

    task automatic push(int t, logic [15:0] v, string tag);
        exp_q.push_back({2'(t), v});
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        if (bus_we || bus_re) begin
            int at;
            at = bus_cle ? 0 : bus_ale ? 1 : bus_we ? 2 : 3;
            if (!active) begin
                chk(0, "R11 strobe while idle", 32'(at), 32'hF);
            end else if (exp_q.size() == 0) begin
                chk(0, "R11 extra bus cycle", {14'(at), bus_dout}, 32'hF);
            end else begin
                logic [17:0] e;
                string tg;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(e[17:16] == 2'(at) && (at == 3 || e[15:0] == bus_dout), tg,
                    {14'(at), bus_dout}, {14'(e[17:16]), e[15:0]});
            end
            if (gap_pending) begin
                chk(cyc == t_ff + RWAIT + 1, "R8 reset idle gap", 32'(cyc - t_ff), 32'(RWAIT + 1));
                gap_pending = 0;
            end
            if (bus_cle && bus_we && bus_dout[7:0] == 8'hFF) begin
                t_ff = cyc; gap_pending = 1;
            end
        end
        if (rd_valid && rd_ready) begin
            chk(rd_data == dev_word(rd_k), "R2/R10 read stream word", 32'(rd_data), 32'(dev_word(rd_k)));
            rd_k++;
        end
        if (wr_valid && wr_ready) wr_k++;
        cyc++;
    end

    // stream drivers with backpressure
    always @(negedge clk) begin
        rd_ready = (cyc % 4) != 1;
        wr_valid = (cyc % 5) != 2;
        wr_data  = host_word(wr_k);
    end

    task automatic push_polls(int npolls, string tag);
        for (int i = 0; i < npolls; i++) begin
            push(0, 16'h0070, tag);
            push(3, 16'h0, tag);
        end
    endtask

    task automatic run_op(int o, int blk, int pg, bit ext, int bp, logic [15:0] sb,
                          logic [15:0] sr, int exp_res, bit poke, string tag);
        longint a;
        int np;
        bit tmo;
        bit bounded;
        int guard;
        a = (longint'(blk) << 17) + (longint'(pg) << 11);
        bounded = !(o == 0 && !ext);
        tmo = bounded && (bp >= RETRY);
        np = tmo ? RETRY : bp + 1;
        exp_q.delete(); tag_q.delete();
        case (o)
            0: begin push(0, 16'h00FF, "R8 reset cmd"); push_polls(np, "R8/R9 reset poll"); end
            1: begin
                push(0, 16'h0090, "R10 id cmd"); push(1, 16'h0000, "R10 id addr");
                for (int i = 0; i < 5; i++) push(3, 16'h0, "R10 id word");
            end
            2: begin
                push(0, 16'h0000, "R2 read cmd");
                push(1, 16'(a & 8'hFF), "R1 addr c0"); push(1, 16'((a >> 8) & 3'h7), "R1 addr c1");
                push(1, 16'((a >> 11) & 8'hFF), "R1 addr c2"); push(1, 16'((a >> 19) & 8'hFF), "R1 addr c3");
                push(1, 16'((a >> 27) & 1), "R1 addr c4");
                push(0, 16'h0030, "R2 read confirm");
                push_polls(np, "R5/R6 read poll");
                if (!tmo) begin
                    push(0, 16'h0000, "R2 read reissue");
                    for (int i = 0; i < WORDS; i++) push(3, 16'h0, "R2 page word");
                end
            end
            3: begin
                push(0, 16'h0080, "R3 prog cmd");
                push(1, 16'(a & 8'hFF), "R1 addr c0"); push(1, 16'((a >> 8) & 3'h7), "R1 addr c1");
                push(1, 16'((a >> 11) & 8'hFF), "R1 addr c2"); push(1, 16'((a >> 19) & 8'hFF), "R1 addr c3");
                push(1, 16'((a >> 27) & 1), "R1 addr c4");
                for (int i = 0; i < WORDS; i++) push(2, host_word(i), "R3/R12 prog word");
                push(0, 16'h0010, "R3 prog confirm");
                push_polls(np, "R5/R7 prog poll");
            end
            default: begin
                push(0, 16'h0060, "R4 erase cmd");
                push(1, 16'((a >> 11) & 8'hFF), "R4 row c0"); push(1, 16'((a >> 19) & 8'hFF), "R4 row c1");
                push(1, 16'((a >> 27) & 8'hFF), "R4 row c2");
                push(0, 16'h00D0, "R4 erase confirm");
                push_polls(np, "R5/R7 erase poll");
            end
        endcase
        @(negedge clk);
        busy_polls = bp; st_busy = sb; st_ready = sr;
        rd_k = 0; wr_k = 0; gap_pending = 0;
        dev_clr = 1'b1;
        @(negedge clk);
        dev_clr = 1'b0;
        op = 3'(o); blk_idx = 11'(blk); pg_idx = 6'(pg); ext_verify = ext;
        start = 1'b1; active = 1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11 busy after accept", 32'(busy), 32'd1);
        guard = 0;
        if (poke) begin
            repeat (20) @(negedge clk);
            op = 3'd4; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
            if (!done) begin
                if (!busy) begin
                    chk(0, "R11 busy dropped before done", 32'(busy), 32'd1);
                    break;
                end
            end
        end
        chk(done == 1'b1, {tag, " done seen"}, 32'(done), 32'd1);
        chk(result == 2'(exp_res), {tag, " result"}, 32'(result), 32'(exp_res));
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R11 done single cycle", {30'd0, done, busy}, 32'd0);
        chk(exp_q.size() == 0, {tag, " missing bus cycles"}, 32'(exp_q.size()), 32'd0);
        active = 0;
    endtask

    nand_op_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .blk_idx(blk_idx),
        .pg_idx(pg_idx), .ext_verify(ext_verify), .busy(busy), .done(done),
        .result(result), .bus_cle(bus_cle), .bus_ale(bus_ale), .bus_we(bus_we),
        .bus_re(bus_re), .bus_dout(bus_dout), .bus_din(bus_din),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 32'(cyc), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R11 reset state", {30'd0, busy, done}, 32'd0);
        chk(!bus_we && !bus_re, "R11 reset strobes", {30'd0, bus_we, bus_re}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8/R9 reset: bit6 alone is not complete; unbounded poll outlasts retry budget
        run_op(0, 0, 0, 0, RETRY + 4, 16'h0040, 16'h0060, 0, 0, "R9 reset unbounded");
        run_op(0, 0, 0, 1, 3, 16'h0040, 16'h00E0, 0, 0, "R8 reset ext");
        run_op(0, 0, 0, 1, 100, 16'h0040, 16'h0060, 2, 0, "R9 reset ext timeout");
        run_op(1, 0, 0, 0, 0, 16'h0, 16'h0040, 0, 0, "R10 read id");
        run_op(2, 1234, 45, 0, 2, 16'h0000, 16'h0040, 0, 0, "R2 page read");
        run_op(2, 2047, 63, 0, 50, 16'h0000, 16'h0040, 2, 0, "R6 read timeout");
        run_op(3, 777, 21, 0, 1, 16'h0000, 16'h0040, 0, 1, "R3 program pass");
        run_op(3, 5, 0, 0, 0, 16'h0000, 16'h0041, 1, 0, "R7 program fail");
        run_op(4, 1365, 0, 0, 4, 16'h0001, 16'h0040, 0, 0, "R4 erase pass");
        run_op(4, 1024, 0, 0, 0, 16'h0000, 16'h0041, 1, 0, "R7 erase fail");
        run_op(4, 3, 0, 0, RETRY, 16'h0000, 16'h0040, 2, 0, "R6 erase timeout at limit");
        // R11: invalid code is ignored
        @(negedge clk);
        op = 3'd6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R11 invalid op ignored", 32'(busy), 32'd0);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && !bus_we && !bus_re, "R11 invalid op no bus cycles",
            {29'd0, busy, bus_we, bus_re}, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule